// File: doc/BRIEF.md
# Floating-Point Stage Reservation Scoreboard

This block decides, cycle by cycle, whether a new floating-point or integer-multiply operation may enter a shared arithmetic pipeline. That pipeline has four shared stage resources: an entry stage, a main stage, a rounding stage and an iterative stage. It also has two multiplier sub-units, A and B. Each operation class holds a fixed set of these resources in each of the cycles after it issues. The scoreboard keeps a window of future cycles. Each slot of the window is a mask of the resources already promised for that cycle.

A request is a class code and a valid bit. The block builds the reservation pattern for that class and compares it with the window in the same cycle. If nothing overlaps, the block raises a grant and reports the result latency of the class. On the clock edge it then merges the pattern into the window. The window moves one cycle forward on every edge, whether or not anything was granted. A refused request leaves the window unchanged. The requester holds its request, and the block judges it again against the window of the next cycle.

Top module: `fpsb_sched`

## Requirements
- R1: Class codes are 0 single add/multiply/compare, 1 single divide, 2 double add/multiply, 3 double conversion, 4 double divide, 5 integer multiply, 6 status-register load, 7 undefined. `grant` is 1 only while `req_valid` is 1 and the class is not 7. `latency` is 0 whenever `grant` is 0.
- R2: After reset the window is empty, so any defined class is granted on an idle pipeline. `grant` and `latency` answer in the same cycle as the request.
- R3: Class 0 holds entry+main at offset 1 and rounding at offset 2, with latency 3. Back-to-back class 0 requests are all granted.
- R4: Class 1 holds entry+main+iterative at offset 1, rounding+iterative at 2, iterative at 3 to 9, main+iterative at 10 and rounding at 11, with latency 12. A second class 1 request is refused for 9 cycles and is granted 10 cycles after the first.
- R5: Class 2 holds entry+main at offset 1, main+rounding at offsets 2 to 6 and rounding at 7, with latency 8. A following class 2 request is granted 6 cycles after the first.
- R6: Class 3 holds entry+main at offset 1, main+rounding at 2 and rounding at 3, with latency 4. A class 0 request one cycle later is refused; two cycles later it is granted.
- R7: Class 4 holds entry+main+iterative at offset 1, main+rounding+iterative at 2, rounding+iterative at 3, iterative at 4 to 19, main+iterative at 20, main+rounding+iterative at 21 and 22, and rounding at 23, with latency 25. A second class 4 request is granted 22 cycles after the first. Offset 23 is held in the window.
- R8: Class 5 holds one multiplier sub-unit at offsets 1 to 4 and rounding at 5, with latency 4. Sub-unit A is tried first and B is used only if A clashes. Two class 5 requests in consecutive cycles are both granted. A third is refused until 4 cycles after the first.
- R9: Neither multiplier sub-unit may be held in a cycle where the main stage is held, whichever of the two was reserved first.
- R10: Class 6 holds nothing at offset 1 and the main stage at offsets 2 to 4, with latency 4. A class 0 request is refused 1 to 3 cycles after it and granted 4 cycles after it.
- R11: A refused request, or one with `req_valid` low, leaves the window unchanged.
- R12: The window moves one cycle per clock. A resource held only at offset 1 blocks no request made in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears the window |
| req_valid | input | 1 | A request is present this cycle |
| req_class | input | 3 | Operation class code (see R1) |
| grant | output | 1 | The request may issue this cycle |
| latency | output | LAT_W (5) | Result latency of the granted class, 0 otherwise |

## Verification
The bench holds a refused request and checks the exact cycle at which it turns into a grant. An off-by-one in the window shift, or a stage range one slot too short or too long, would move that cycle. The double divide is checked out to offset 23, so a window that drops its deepest slots would grant the second divide early. The integer multiply is checked with both sub-units busy, and also placed against the main stage in both orders. A design that ignores the exclusion rule, or never falls back to sub-unit B, would grant or refuse at the wrong points. A refused divide is followed by a short operation that its pattern would have blocked, so a design that merges refused patterns into the window would refuse that operation.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;

    typedef enum logic [2:0] {
        CLS_SP_ARITH = 3'd0,
        CLS_SP_DIV   = 3'd1,
        CLS_DP_ARITH = 3'd2,
        CLS_DP_CONV  = 3'd3,
        CLS_DP_DIV   = 3'd4,
        CLS_IMUL     = 3'd5,
        CLS_STAT_LD  = 3'd6,
        CLS_NONE     = 3'd7
    } op_e;

    // One bit per shared resource held in a given future cycle.
    typedef struct packed {
        logic mb;   // multiplier sub-unit B
        logic ma;   // multiplier sub-unit A
        logic f3;   // iterative stage
        logic f2;   // rounding stage
        logic f1;   // main stage
        logic f0;   // entry stage
    } res_t;

    // Deepest offset any class reserves.
    localparam int MAX_SPAN = 23;

    function automatic logic [4:0] op_latency(input op_e c);
        logic [4:0] l;
        case (c)
            CLS_SP_ARITH: l = 5'd3;
            CLS_SP_DIV:   l = 5'd12;
            CLS_DP_ARITH: l = 5'd8;
            CLS_DP_CONV:  l = 5'd4;
            CLS_DP_DIV:   l = 5'd25;
            CLS_IMUL:     l = 5'd4;
            CLS_STAT_LD:  l = 5'd4;
            default:      l = 5'd0;
        endcase
        return l;
    endfunction

    // Resources held by class c at offset o (1 = first cycle after issue).
    function automatic res_t op_slot(input op_e c, input int o, input logic use_b);
        res_t r;
        r = '0;
        case (c)
            CLS_SP_ARITH: begin
                if (o == 1) begin r.f0 = 1'b1; r.f1 = 1'b1; end
                if (o == 2) r.f2 = 1'b1;
            end
            CLS_SP_DIV: begin
                if (o >= 1 && o <= 10) r.f3 = 1'b1;
                if (o == 1) begin r.f0 = 1'b1; r.f1 = 1'b1; end
                if (o == 2 || o == 11) r.f2 = 1'b1;
                if (o == 10) r.f1 = 1'b1;
            end
            CLS_DP_ARITH: begin
                if (o >= 1 && o <= 6) r.f1 = 1'b1;
                if (o == 1) r.f0 = 1'b1;
                if (o >= 2 && o <= 7) r.f2 = 1'b1;
            end
            CLS_DP_CONV: begin
                if (o == 1 || o == 2) r.f1 = 1'b1;
                if (o == 1) r.f0 = 1'b1;
                if (o == 2 || o == 3) r.f2 = 1'b1;
            end
            CLS_DP_DIV: begin
                if (o >= 1 && o <= 22) r.f3 = 1'b1;
                if (o == 1) r.f0 = 1'b1;
                if (o == 1 || o == 2 || (o >= 20 && o <= 22)) r.f1 = 1'b1;
                if (o == 2 || o == 3 || o == 21 || o == 22 || o == 23) r.f2 = 1'b1;
            end
            CLS_IMUL: begin
                if (o >= 1 && o <= 4) begin
                    r.ma = !use_b;
                    r.mb = use_b;
                end
                if (o == 5) r.f2 = 1'b1;
            end
            CLS_STAT_LD: begin
                if (o >= 2 && o <= 4) r.f1 = 1'b1;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fpsb_pattern.sv
module fpsb_pattern
    import fpsb_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  op_e                  cls,
    input  logic                 use_b,
    output res_t [DEPTH-1:0]     pat
);
    // Slot g holds the resources for offset g+1.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign pat[g] = op_slot(cls, g + 1, use_b);
    end
endmodule

// File: rtl/fpsb_clash.sv
module fpsb_clash
    import fpsb_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  res_t [DEPTH-1:0] pat,
    input  res_t [DEPTH-1:0] win,
    output logic             hit
);
    logic [DEPTH-1:0] hit_v;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        // Same resource twice, or a multiplier sub-unit against the main stage.
        assign hit_v[g] = (|(pat[g] & win[g]))
                        | (pat[g].f1 & (win[g].ma | win[g].mb))
                        | ((pat[g].ma | pat[g].mb) & win[g].f1);
    end

    assign hit = |hit_v;
endmodule

// File: rtl/fpsb_sched.sv
module fpsb_sched
    import fpsb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_class,
    output logic             grant,
    output logic [LAT_W-1:0] latency
);
    localparam int TOP = DEPTH - 1;

    typedef struct packed {
        res_t [DEPTH-1:0] win;   // win[i] = resources held at offset i+1
    } state_t;

    state_t st_d, st_q;

    op_e              cls;
    res_t [DEPTH-1:0] pat_a, pat_b, pat_sel;
    logic             hit_a, hit_b, legal;

    assign cls = op_e'(req_class);

    fpsb_pattern #(.DEPTH(DEPTH)) u_pat_a (.cls(cls), .use_b(1'b0), .pat(pat_a));
    fpsb_pattern #(.DEPTH(DEPTH)) u_pat_b (.cls(cls), .use_b(1'b1), .pat(pat_b));

    fpsb_clash #(.DEPTH(DEPTH)) u_clash_a (.pat(pat_a), .win(st_q.win), .hit(hit_a));
    fpsb_clash #(.DEPTH(DEPTH)) u_clash_b (.pat(pat_b), .win(st_q.win), .hit(hit_b));

    always_comb begin
        legal   = (cls != CLS_NONE);
        // Patterns differ only for the multiply, so hit_a == hit_b elsewhere.
        grant   = req_valid && legal && !(hit_a && hit_b);
        pat_sel = hit_a ? pat_b : pat_a;
        latency = grant ? LAT_W'(op_latency(cls)) : '0;

        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            // After the edge, today's offset i+2 becomes offset i+1.
            if (i < TOP) begin
                st_d.win[i] = st_q.win[i+1] | (grant ? pat_sel[i+1] : res_t'('0));
            end else begin
                st_d.win[i] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fpsb_sched_chk.sv
module fpsb_sched_chk #(
    parameter int LAT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_class,
    input logic             grant,
    input logic [LAT_W-1:0] latency
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    logic g_sp, g_sdiv, g_dadd, g_ddiv, g_mul, g_stat;
    assign g_sp   = grant && req_class == 3'd0;
    assign g_sdiv = grant && req_class == 3'd1;
    assign g_dadd = grant && req_class == 3'd2;
    assign g_ddiv = grant && req_class == 3'd4;
    assign g_mul  = grant && req_class == 3'd5;
    assign g_stat = grant && req_class == 3'd6;

    p_grant_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (req_valid && req_class != 3'd7));

    p_lat_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> latency == '0);

    p_div_iter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (g_sdiv || g_ddiv)) |=> !(g_sdiv || g_ddiv));

    p_dadd_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && g_dadd) |=> !g_dadd);

    p_ddiv_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        g_ddiv |-> latency == LAT_W'(25));

    p_mul_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && g_mul && $past(g_mul)) |=> !g_mul);

    p_mul_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && g_mul) |=> !g_sp);

    p_stat_main_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && g_stat) |=> !(g_sp || g_mul));
endmodule

bind fpsb_sched fpsb_sched_chk #(.LAT_W(LAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_class (req_class),
    .grant     (grant),
    .latency   (latency)
);

// File: tb/sim_fpsb_sched.sv
`timescale 1ns/1ps
module sim_fpsb_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_class = 3'd0;
    logic       grant;
    logic [4:0] latency;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    fpsb_sched u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_class(req_class), .grant(grant), .latency(latency)
    );

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; req_class = 3'd0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one request at the falling edge and check the answer before the next rising edge.
    task automatic step(input logic v, input logic [2:0] c,
                        input logic eg, input logic [4:0] el, input string tag);
        @(negedge clk);
        req_valid = v; req_class = c;
        #5;
        n_chk++;
        if (grant !== eg || latency !== el) begin
            n_bad++;
            $display("FAIL %s: class %0d grant=%b latency=%0d, expected grant=%b latency=%0d",
                     tag, c, grant, latency, eg, el);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic t_reset_and_classes();
        logic [4:0] lat [7];
        lat[0] = 5'd3; lat[1] = 5'd12; lat[2] = 5'd8; lat[3] = 5'd4;
        lat[4] = 5'd25; lat[5] = 5'd4; lat[6] = 5'd4;
        do_reset();
        step(1'b0, 3'd0, 1'b0, 5'd0, "R1 idle after reset");
        for (int c = 0; c < 7; c++) begin
            do_reset();
            step(1'b1, 3'(c), 1'b1, lat[c], "R2 empty window grant");
        end
        do_reset();
        step(1'b1, 3'd7, 1'b0, 5'd0, "R1 undefined class");
        // Invalid divide request must not reserve anything.
        do_reset();
        step(1'b0, 3'd1, 1'b0, 5'd0, "R1 valid low");
        step(1'b1, 3'd1, 1'b1, 5'd12, "R11 no reservation from invalid");
    endtask

    task automatic t_sp_stream();
        do_reset();
        for (int i = 0; i < 4; i++) step(1'b1, 3'd0, 1'b1, 5'd3, "R3 back to back");
    endtask

    task automatic t_sdiv_hold();
        do_reset();
        step(1'b1, 3'd1, 1'b1, 5'd12, "R4 first divide");
        for (int i = 1; i <= 9; i++) step(1'b1, 3'd1, 1'b0, 5'd0, "R4 iterative busy");
        step(1'b1, 3'd1, 1'b1, 5'd12, "R4 granted at +10");
    endtask

    task automatic t_refused_no_effect();
        do_reset();
        step(1'b1, 3'd1, 1'b1, 5'd12, "R11 divide");
        step(1'b1, 3'd4, 1'b0, 5'd0, "R11 double divide refused");
        step(1'b1, 3'd0, 1'b1, 5'd3, "R11 refused pattern not merged");
    endtask

    task automatic t_dadd_hold();
        do_reset();
        step(1'b1, 3'd2, 1'b1, 5'd8, "R5 first");
        for (int i = 1; i <= 5; i++) step(1'b1, 3'd2, 1'b0, 5'd0, "R5 main busy");
        step(1'b1, 3'd2, 1'b1, 5'd8, "R5 granted at +6");
    endtask

    task automatic t_conv_then_sp();
        do_reset();
        step(1'b1, 3'd3, 1'b1, 5'd4, "R6 conversion");
        step(1'b1, 3'd0, 1'b0, 5'd0, "R6 main held at +2");
        step(1'b1, 3'd0, 1'b1, 5'd3, "R6 retry granted");
    endtask

    task automatic t_ddiv_deep();
        do_reset();
        step(1'b1, 3'd4, 1'b1, 5'd25, "R7 first");
        idle(2);
        step(1'b1, 3'd0, 1'b1, 5'd3, "R7 interleaved single op");
        for (int i = 4; i <= 21; i++) step(1'b1, 3'd4, 1'b0, 5'd0, "R7 iterative busy");
        step(1'b1, 3'd4, 1'b1, 5'd25, "R7 granted at +22");
    endtask

    task automatic t_mul_units();
        do_reset();
        step(1'b1, 3'd5, 1'b1, 5'd4, "R8 first on A");
        step(1'b1, 3'd5, 1'b1, 5'd4, "R8 second on B");
        step(1'b1, 3'd5, 1'b0, 5'd0, "R8 both busy +2");
        step(1'b1, 3'd5, 1'b0, 5'd0, "R8 both busy +3");
        step(1'b1, 3'd5, 1'b1, 5'd4, "R8 A free at +4");
    endtask

    task automatic t_exclusion();
        do_reset();
        step(1'b1, 3'd5, 1'b1, 5'd4, "R9 multiply");
        for (int i = 1; i <= 3; i++) step(1'b1, 3'd0, 1'b0, 5'd0, "R9 main vs sub-unit");
        step(1'b1, 3'd0, 1'b1, 5'd3, "R9 granted at +4");
        do_reset();
        step(1'b1, 3'd6, 1'b1, 5'd4, "R9 status load");
        for (int i = 1; i <= 3; i++) step(1'b1, 3'd5, 1'b0, 5'd0, "R9 sub-unit vs main");
        step(1'b1, 3'd5, 1'b1, 5'd4, "R9 multiply at +4");
        do_reset();
        step(1'b1, 3'd0, 1'b1, 5'd3, "R12 single op");
        step(1'b1, 3'd5, 1'b1, 5'd4, "R12 offset-1 main expired");
    endtask

    task automatic t_stat_gap();
        do_reset();
        step(1'b1, 3'd6, 1'b1, 5'd4, "R10 status load");
        for (int i = 1; i <= 3; i++) step(1'b1, 3'd0, 1'b0, 5'd0, "R10 main held");
        step(1'b1, 3'd0, 1'b1, 5'd3, "R10 granted at +4");
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_and_classes();
        t_sp_stream();
        t_sdiv_hold();
        t_refused_no_effect();
        t_dadd_hold();
        t_conv_then_sp();
        t_ddiv_deep();
        t_mul_units();
        t_exclusion();
        t_stat_gap();
        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule